// File: doc/BRIEF.md
# Return-From-Exception Status Restore Unit

This unit computes the processor state that follows a return-from-exception instruction. The status word is a stack of flag fields. On a return, the saved fields are popped into the live field by a right shift, while the two most significant bits stay where they are.

When the popped state selects user mode, the unit swaps stack pointers. The live stack pointer is saved as the kernel stack pointer, and the user stack pointer becomes live. The unit also sets the pending flag when the restored state does not have the restart flag set.

The surrounding pipeline presents the current status word, the current stack pointer and the user stack pointer, and pulses `rfe_i` for one cycle. The three results are registered on that edge and hold until the next pulse.

Top module: `rfe_status_unit`

## Requirements
- R1: While `rst_i` is high, `status_o`, `sp_o` and `ksp_o` are all zero. They stay zero until the first `rfe_i` pulse.
- R2: On the edge where `rfe_i` is high, `status_o[31:30]` takes the value of `status_i[31:30]`.
- R3: After a return, `status_o[29:28]` is zero.
- R4: After a return, `status_o[27:0]` equals `status_i[27:0]` shifted right by 10 places. The only exception is the pending bit described in R7.
- R5: The user flag is bit 6, and the restart flag is bit 8. Before the shift these are bits 16 and 18 of `status_i`. If bit 6 of the shifted status is 1, then `sp_o` takes `usp_i` and `ksp_o` takes `sp_i`.
- R6: If bit 6 of the shifted status is 0, then `sp_o` takes `sp_i` and `ksp_o` keeps its previous value.
- R7: The pending flag is bit 7. If bit 8 of the shifted status is 0, bit 7 of `status_o` is 1.
- R8: If bit 8 of the shifted status is 1, bit 7 of `status_o` equals `status_i[17]`, which is the shifted value.
- R9: In a cycle with `rfe_i` low, all three outputs hold their value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rfe_i | input | 1 | Return-from-exception strobe |
| status_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| status_o | output | 32 | Restored status word |
| sp_o | output | 32 | Stack pointer after the return |
| ksp_o | output | 32 | Saved kernel stack pointer |

## Verification
Every result is registered, so a wrong computation shows at the ports one cycle after the `rfe_i` edge. A shift by the wrong distance, or a mask on the wrong bits, corrupts `status_o` at that point. A user-flag decode from the wrong bit swaps the stack pointers for the wrong combinations. A lost hold shows as a change in an output during a cycle without a strobe. The bench therefore sweeps every pairing of the user and restart flags over several background patterns, then runs a pseudo-random series. After each operation it compares the outputs with arithmetic expectations.

// File: rtl/rfe_status_unit.sv
module rfe_status_unit #(
  parameter int W      = 32,
  parameter int SHIFT  = 10,
  parameter int KEEP   = 2,
  parameter int GAP    = 2,
  parameter int U_BIT  = 6,
  parameter int P_BIT  = 7,
  parameter int R_BIT  = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         rfe_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o
);
  localparam logic [W-1:0] ONES      = {W{1'b1}};
  localparam logic [W-1:0] KEEP_MASK = ~(ONES >> KEEP);
  localparam logic [W-1:0] LOW_MASK  = ONES >> (KEEP + GAP);

  logic [W-1:0] popped, restored;
  logic         to_user;

  assign popped   = (status_i & KEEP_MASK) | ((status_i & LOW_MASK) >> SHIFT);
  assign to_user  = popped[U_BIT];
  assign restored = popped | ({{(W-1){1'b0}}, ~popped[R_BIT]} << P_BIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      status_o <= '0;
      sp_o     <= '0;
      ksp_o    <= '0;
    end else if (rfe_i) begin
      status_o <= restored;
      sp_o     <= to_user ? usp_i : sp_i;
      if (to_user) ksp_o <= sp_i;
    end
  end

  AST_TOP_KEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    rfe_i |=> status_o[W-1 -: KEEP] == $past(status_i[W-1 -: KEEP])); // R2
  AST_GAP_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    rfe_i |=> status_o[W-KEEP-1 -: GAP] == '0); // R3
  AST_USER_SWAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (rfe_i && status_i[U_BIT+SHIFT]) |=> (sp_o == $past(usp_i) && ksp_o == $past(sp_i))); // R5
  AST_KERNEL_STAY: assert property (@(posedge clk_i) disable iff (rst_i)
    (rfe_i && !status_i[U_BIT+SHIFT]) |=> (sp_o == $past(sp_i) && $stable(ksp_o))); // R6
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (rfe_i && !status_i[R_BIT+SHIFT]) |=> status_o[P_BIT]); // R7
  AST_PEND_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
    (rfe_i && status_i[R_BIT+SHIFT]) |=> status_o[P_BIT] == $past(status_i[P_BIT+SHIFT])); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rfe_i |=> ($stable(status_o) && $stable(sp_o) && $stable(ksp_o))); // R9
endmodule

// File: tb/tb_rfe_status_unit.sv
module tb_rfe_status_unit;
  logic clk = 1'b0, rst = 1'b1, rfe = 1'b0;
  logic [31:0] st = '0, sp = '0, usp = '0;
  logic [31:0] st_o, sp_o, ksp_o;
  int total = 0, passed = 0;
  logic [31:0] exp_ksp = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  rfe_status_unit dut (.clk_i(clk), .rst_i(rst), .rfe_i(rfe), .status_i(st),
    .sp_i(sp), .usp_i(usp), .status_o(st_o), .sp_o(sp_o), .ksp_o(ksp_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  task automatic do_rfe(input logic [31:0] s, input logic [31:0] p, input logic [31:0] u);
    logic [31:0] e;
    logic user;
    e = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    user = e[6];
    if (!e[8]) e = e | 32'h80;
    @(negedge clk);
    st = s; sp = p; usp = u; rfe = 1'b1;
    @(negedge clk);
    rfe = 1'b0;
    if (user) exp_ksp = p;
    chk("R2/R3/R4/R7/R8 status", st_o, e);
    chk(user ? "R5 sp" : "R6 sp", sp_o, user ? u : p);
    chk(user ? "R5 ksp" : "R6 ksp", ksp_o, exp_ksp);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #2_000_000;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    st = 32'hFFFF_FFFF; sp = 32'h1; usp = 32'h2;
    @(negedge clk);
    chk("R1 status in reset", st_o, 32'h0);
    chk("R1 sp in reset", sp_o, 32'h0);
    chk("R1 ksp in reset", ksp_o, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 status after reset", st_o, 32'h0);
    chk("R1 ksp after reset", ksp_o, 32'h0);

    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] s;
        case (b)
          0: s = 32'h0000_0000;
          1: s = 32'hFFFF_FFFF;
          2: s = 32'hA5A5_A5A5;
          default: s = 32'h5A5A_5A5A;
        endcase
        s[16] = c[0];
        s[17] = c[1];
        s[18] = c[2];
        do_rfe(s, 32'h1000_0000 + 32'(b * 8 + c), 32'h2000_0000 + 32'(b * 8 + c));
      end
    end

    // R9: inputs change while the strobe is low
    do_rfe(32'h0001_0000, 32'hAAAA_0001, 32'hBBBB_0001);
    begin
      logic [31:0] hs, hp, hk;
      hs = st_o; hp = sp_o; hk = ksp_o;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        st = ~st; sp = sp + 32'd7; usp = usp ^ 32'hFFFF;
      end
      @(negedge clk);
      chk("R9 status hold", st_o, hs);
      chk("R9 sp hold", sp_o, hp);
      chk("R9 ksp hold", ksp_o, hk);
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] s, p;
      step_lfsr(); s = lfsr;
      step_lfsr(); p = lfsr;
      step_lfsr();
      do_rfe(s, p, lfsr);
    end

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule